// File: doc/BRIEF.md
# Byte-Swappable Parallel Result Port

This block is the read-out side of a converter that holds one 16-bit result word. A load interface captures a new result into a holding register. A host reads that register over a 16-bit parallel bus using an active-low chip select and an active-low read strobe. The bus is made of two 8-bit lanes. Each lane has its own output enable, which drives the tri-state pad buffers outside this block. Both enables are off unless a read is in progress.

A swap select chooses which half of the word appears on which lane. With swap low, the low byte is on the lower lane and the high byte is on the upper lane. With swap high, the two bytes are exchanged. A host with only an 8-bit bus wires its data to one lane and ties the swap select to an address line. It then fetches the whole word in two reads from consecutive addresses.

The port behaves the same whichever parallel read mode the converter uses. The load side is a valid/ready stream. A word transfers on a clock edge where `ld_valid` and `ld_ready` are both high. `ld_ready` drops while a read is active, so the producer must hold `ld_valid` and `ld_data` until ready returns. This stops the word from changing under the host in the middle of a read.

Top module: `byteswap_result_port`

## Requirements
- R1: With `swap` low and a read active, `bus_q[7:0]` carries result bits [7:0] and `bus_q[15:8]` carries result bits [15:8].
- R2: With `swap` high and a read active, `bus_q[7:0]` carries result bits [15:8] and `bus_q[15:8]` carries result bits [7:0].
- R3: A read is active only when `cs_n` = 0 and `rd_n` = 0 and `rst` = 0. Then `lane_oe` = 2'b11. Otherwise `lane_oe` = 2'b00 and `bus_q` = 0. Bit 0 of `lane_oe` enables `bus_q[7:0]` and bit 1 enables `bus_q[15:8]`.
- R4: `swap` acts combinationally. Changing it between two reads, with no clock edge in between, changes which byte appears on a lane.
- R5: A word on `ld_data` is captured at a rising clock edge where `ld_valid` = 1 and `ld_ready` = 1. Every later read returns that word.
- R6: `ld_ready` is 0 whenever `cs_n` = 0 and `rd_n` = 0. A word offered by `ld_valid` at such an edge is not captured, and the stored result does not change.
- R7: A synchronous active-high `rst` clears the stored result to zero. While `rst` is high, both lane enables are 0.
- R8: Without an accepted load, the stored result holds its value across any number of reads and clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | A new result word is offered |
| ld_ready | output | 1 | The port can accept a word (low during a read) |
| ld_data | input | 16 | New result word |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| swap | input | 1 | Byte lane exchange select |
| bus_q | output | 16 | Bus data; each lane is zero when its enable is off |
| lane_oe | output | 2 | Per-lane output enables for the pad buffers |

## Verification
The bench sweeps a set of computed result words through every combination of chip select, read strobe and swap select. A design with the lane routing reversed or bits crossed between lanes fails the byte checks. A design that gates the enables on only one of the two strobes drives the bus while idle. The bench toggles swap between two reads with no clock edge in between. A design that registered the select would return the same byte twice. The bench also offers a load in the middle of a read, and offers a load while reset is high. A port that accepts the first would corrupt a two-read fetch. A port that accepts the second would come out of reset with a non-zero result.

// File: rtl/byteport_pkg.sv
package byteport_pkg;
  // Source lane index for output lane `lane` of `lanes` lanes under the swap select
  function automatic int unsigned lane_src(input int unsigned lane,
                                           input int unsigned lanes,
                                           input logic        swap);
    return swap ? (lanes - 1 - lane) : lane;
  endfunction
endpackage

// File: rtl/result_hold.sv
module result_hold #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (accept) q <= din;
  end

  // R5
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> q == $past(din));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(q));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> q == '0);
endmodule

// File: rtl/port_ctrl.sv
module port_ctrl (
  input  logic rst,
  input  logic cs_n,
  input  logic rd_n,
  input  logic ld_valid,
  output logic rd_active,
  output logic ld_ready,
  output logic accept
);
  logic strobed;

  always_comb begin
    strobed   = ~cs_n & ~rd_n;
    rd_active = strobed & ~rst;
    ld_ready  = ~strobed;
    accept    = ld_valid & ld_ready & ~rst;
  end

  // R6
  no_load_in_read_chk: assert final (!(accept && !cs_n && !rd_n));
endmodule

// File: rtl/lane_mux.sv
module lane_mux
  import byteport_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2
) (
  input  logic [LANE_W*LANES-1:0] word,
  input  logic                    swap,
  input  logic                    en,
  output logic [LANE_W*LANES-1:0] bus,
  output logic [LANES-1:0]        oe
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned SRC_STRAIGHT = lane_src(g, LANES, 1'b0);
    localparam int unsigned SRC_SWAPPED  = lane_src(g, LANES, 1'b1);
    logic [LANE_W-1:0] pick;
    always_comb begin
      pick = swap ? word[SRC_SWAPPED*LANE_W +: LANE_W]
                  : word[SRC_STRAIGHT*LANE_W +: LANE_W];
      bus[g*LANE_W +: LANE_W] = en ? pick : '0;
      oe[g] = en;
    end
  end
endmodule

// File: rtl/byteswap_result_port.sv
module byteswap_result_port #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              swap,
  output logic [DATA_W-1:0] bus_q,
  output logic [LANES-1:0]  lane_oe
);
  logic              rd_active;
  logic              accept;
  logic [DATA_W-1:0] result;

  port_ctrl u_ctrl (
    .rst      (rst),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .ld_valid (ld_valid),
    .rd_active(rd_active),
    .ld_ready (ld_ready),
    .accept   (accept)
  );

  result_hold #(.DATA_W(DATA_W)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .accept(accept),
    .din   (ld_data),
    .q     (result)
  );

  lane_mux #(.LANE_W(LANE_W), .LANES(LANES)) u_mux (
    .word(result),
    .swap(swap),
    .en  (rd_active),
    .bus (bus_q),
    .oe  (lane_oe)
  );

  // R3
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_oe != '0) |-> (!cs_n && !rd_n));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n || rd_n) |-> (bus_q == '0 && lane_oe == '0));

  // R7
  reset_lanes_off_chk: assert property (@(posedge clk)
    rst |-> lane_oe == '0);

  // R6
  ready_low_in_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n) |-> !ld_ready);

  // R8
  read_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n && $past(!cs_n && !rd_n) && $stable(swap)) |-> $stable(bus_q));
endmodule

// File: tb/byteswap_result_port_test.sv
module byteswap_result_port_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        ld_valid;
  logic        ld_ready;
  logic [15:0] ld_data;
  logic        cs_n, rd_n, swap;
  logic [15:0] bus_q;
  logic [1:0]  lane_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  byteswap_result_port uut (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_data(ld_data), .cs_n(cs_n), .rd_n(rd_n), .swap(swap),
    .bus_q(bus_q), .lane_oe(lane_oe)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] exp_bus(input logic [15:0] w, input logic sw,
                                          input logic en);
    if (!en) return 16'h0000;
    return sw ? {w[7:0], w[15:8]} : w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // wait to the falling edge, where inputs change
  task automatic to_neg();
    @(negedge clk);
  endtask

  task automatic load_word(input logic [15:0] w);
    to_neg();
    ld_valid = 1'b1; ld_data = w;
    to_neg();
    ld_valid = 1'b0;
  endtask

  initial begin
    int unsigned cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic [15:0] held;
    rst = 1'b1; ld_valid = 1'b0; ld_data = 16'h0; cs_n = 1'b1; rd_n = 1'b1; swap = 1'b0;
    repeat (3) to_neg();
    rst = 1'b0;
    // reset state: idle, ready, read returns zero (R7, R3)
    #1;
    check("R3 idle oe", {30'd0, lane_oe}, 32'd0);
    check("R6 ready idle", {31'd0, ld_ready}, 32'd1);
    cs_n = 1'b0; rd_n = 1'b0; #1;
    check("R7 result zero after reset", {16'd0, bus_q}, 32'd0);
    check("R3 oe on read", {30'd0, lane_oe}, 32'd3);
    cs_n = 1'b1; rd_n = 1'b1;

    // sweep words across all strobe and swap combinations (R1 R2 R3 R5)
    for (int k = 0; k < 40; k++) begin
      w = 16'(k * 16'h1357) ^ 16'(k << 9) ^ 16'hA50F;
      if (k == 1) w = 16'hFFFF;
      if (k == 2) w = 16'h0000;
      if (k == 3) w = 16'h00FF;
      load_word(w);
      for (int c = 0; c < 8; c++) begin
        cs_n = c[0]; rd_n = c[1]; swap = c[2];
        #1;
        check(swap ? "R2 bus" : "R1 bus", {16'd0, bus_q},
              {16'd0, exp_bus(w, swap, !cs_n && !rd_n)});
        check("R3 oe", {30'd0, lane_oe}, (!cs_n && !rd_n) ? 32'd3 : 32'd0);
        #1;
      end
      cs_n = 1'b1; rd_n = 1'b1;
    end
    held = w;

    // two byte reads on the low lane with swap toggled, no clock edge (R4)
    to_neg();
    cs_n = 1'b0; rd_n = 1'b0; swap = 1'b0; #1;
    check("R4 first read low lane", {24'd0, bus_q[7:0]}, {24'd0, held[7:0]});
    rd_n = 1'b1; #1;
    swap = 1'b1; rd_n = 1'b0; #1;
    check("R4 second read low lane", {24'd0, bus_q[7:0]}, {24'd0, held[15:8]});

    // load offered during a read is refused (R6), result kept (R8)
    check("R6 ready low in read", {31'd0, ld_ready}, 32'd0);
    ld_valid = 1'b1; ld_data = ~held;
    to_neg(); to_neg();
    check("R6 result unchanged", {16'd0, bus_q}, {16'd0, exp_bus(held, 1'b1, 1'b1)});
    // producer holds valid; it transfers once the read ends (R5)
    cs_n = 1'b1; rd_n = 1'b1; #1;
    check("R5 ready back", {31'd0, ld_ready}, 32'd1);
    to_neg();
    ld_valid = 1'b0;
    cs_n = 1'b0; rd_n = 1'b0; swap = 1'b0; #1;
    check("R5 delayed transfer", {16'd0, bus_q}, {16'd0, ~held});
    held = ~held;

    // many edges with no load (R8)
    repeat (20) to_neg();
    #1;
    check("R8 hold across edges", {16'd0, bus_q}, {16'd0, held});

    // reset with a read and a load pending (R7)
    to_neg();
    rst = 1'b1; ld_valid = 1'b1; ld_data = 16'h1234; #1;
    check("R7 lanes off in reset", {30'd0, lane_oe}, 32'd0);
    check("R7 bus quiet in reset", {16'd0, bus_q}, 32'd0);
    cs_n = 1'b1; rd_n = 1'b1; #1;
    to_neg();
    rst = 1'b0; ld_valid = 1'b0;
    cs_n = 1'b0; rd_n = 1'b0; #1;
    check("R7 cleared", {16'd0, bus_q}, 32'd0);
    cs_n = 1'b1; rd_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule